// File: doc/BRIEF.md
# Port Input Debounce Filter with Shared Time Base

This block removes contact bounce and short glitches from the inputs of one general-purpose I/O port. Each pin carries its own enable bit. When the bit is clear, the pin passes its already synchronized raw level straight to the filtered output. When the bit is set, the filtered output changes only after the raw level has stayed at a new value for a programmed number of millisecond ticks. The filtered levels feed the port's input register and its interrupt detector.

The debounce time is held in a single count register that every pin of the port shares. Each enabled pin still has its own stability counter, so pins that change at different moments settle independently while using the same time base. Enable bits are written through a masked write: the upper half of the write word selects which pins are updated and the lower half gives their new values. The millisecond tick comes from outside the block as a one-clock pulse.

Top module: `port_debounce`

## Requirements
- R1: While `rst` is high the filtered state loads the raw levels, the counters clear, every enable bit clears and the count becomes 0. After reset `pin_flt` equals `pin_raw`.
- R2: A pin whose enable bit is 0 drives `pin_flt` combinationally from `pin_raw`, in the same cycle and without waiting for a tick.
- R3: A write with `cfg_addr`=0 updates enable bit i to `cfg_wdata[i]` only where the mask bit `cfg_wdata[PINS+i]` is 1. Enable bits whose mask bit is 0 keep their value.
- R4: A write with `cfg_addr`=1 loads the count from `cfg_wdata[CNT_W-1:0]` (1 to 255 by default). An enabled pin whose raw level differs from its filtered level takes the new level on the N-th tick after the raw level has been stable for one full clock, where N is the count, and not before.
- R5: Any change of a pin's raw level clears that pin's counter, so a glitch during the wait restarts the full debounce time.
- R6: A count of 0 makes every pin pass its raw level through, even when its enable bit is 1.
- R7: The one count applies to all enabled pins. Each pin keeps its own counter, so two pins that change at different times update on different ticks.
- R8: If the count is lowered below a pin's current counter value, that pin updates on its next tick.
- R9: A filtered output that is in debounce mode changes only on a clock edge where `ms_tick` is high.
- R10: If the raw level returns to the filtered level before the count expires, the filtered output never changes and the pending count is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects masked enable register, 1 selects count register |
| cfg_wdata | input | 2*PINS | Write data: mask in upper half and values in lower half, or count in low bits |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| pin_raw | input | PINS | Synchronized raw pin levels |
| pin_flt | output | PINS | Filtered pin levels |

## Verification
The bench builds the block with its defaults, eight pins and an 8-bit count. At these values the largest count of 255 can be run in full on one pin, and the two-pin shared-count case and the masked write over a whole byte of pins can both be checked. The chosen tick spacing lets each check land on the exact tick that should, or should not, move the output.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
   // Register selector on the configuration port
   typedef enum logic {
      PDB_REG_ENABLE = 1'b0,
      PDB_REG_COUNT  = 1'b1
   } pdb_reg_e;
endpackage

// File: rtl/pdb_cfg_regs.sv
module pdb_cfg_regs #(
   parameter int PINS  = 8,
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic              addr,
   input  logic [2*PINS-1:0] wdata,
   output logic [PINS-1:0]   en_q,
   output logic [CNT_W-1:0]  limit_q
);
   import pdb_pkg::*;

   localparam int WD_W = 2 * PINS;

   if (CNT_W > WD_W) begin : g_bad_width
      $error("pdb_cfg_regs: count does not fit in the write word");
   end

   logic wr_en_reg;
   logic wr_cnt_reg;

   assign wr_en_reg  = we && (pdb_reg_e'(addr) == PDB_REG_ENABLE);
   assign wr_cnt_reg = we && (pdb_reg_e'(addr) == PDB_REG_COUNT);

   for (genvar i = 0; i < PINS; i++) begin : g_en_bit
      always_ff @(posedge clk) begin
         if (rst) begin
            en_q[i] <= 1'b0;
         end else if (wr_en_reg && wdata[PINS+i]) begin
            en_q[i] <= wdata[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         limit_q <= '0;
      end else if (wr_cnt_reg) begin
         limit_q <= wdata[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             raw,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   output logic             flt
);
   localparam int NXT_W = CNT_W + 1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("pdb_pin_filter: counter width must be at least one");
   end

   logic             flt_q;
   logic             raw_prev;
   logic [CNT_W-1:0] cnt_q;
   logic [NXT_W-1:0] cnt_nxt;
   logic             bypass;
   logic             settled;

   assign bypass  = !en || (limit == '0);
   assign settled = (raw == flt_q) || (raw != raw_prev);
   assign cnt_nxt = {1'b0, cnt_q} + NXT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         flt_q    <= raw;
         raw_prev <= raw;
         cnt_q    <= '0;
      end else begin
         raw_prev <= raw;
         if (bypass) begin
            flt_q <= raw;
            cnt_q <= '0;
         end else if (settled) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_nxt >= {1'b0, limit}) begin
               flt_q <= raw;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_nxt[CNT_W-1:0];
            end
         end
      end
   end

   assign flt = bypass ? raw : flt_q;
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
   parameter int PINS  = 8,
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [2*PINS-1:0] cfg_wdata,
   input  logic              ms_tick,
   input  logic [PINS-1:0]   pin_raw,
   output logic [PINS-1:0]   pin_flt
);
   if (PINS < 1) begin : g_bad_pins
      $error("port_debounce: at least one pin is required");
   end

   logic [PINS-1:0]  en_q;
   logic [CNT_W-1:0] limit_q;

   pdb_cfg_regs #(
      .PINS  (PINS),
      .CNT_W (CNT_W)
   ) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .en_q    (en_q),
      .limit_q (limit_q)
   );

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      pdb_pin_filter #(
         .CNT_W (CNT_W)
      ) u_flt (
         .clk   (clk),
         .rst   (rst),
         .tick  (ms_tick),
         .raw   (pin_raw[p]),
         .en    (en_q[p]),
         .limit (limit_q),
         .flt   (pin_flt[p])
      );
   end
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
   parameter int PINS  = 8,
   parameter int CNT_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_we,
   input logic              cfg_addr,
   input logic [2*PINS-1:0] cfg_wdata,
   input logic              ms_tick,
   input logic [PINS-1:0]   pin_raw,
   input logic [PINS-1:0]   pin_flt,
   input logic [PINS-1:0]   en_q,
   input logic [CNT_W-1:0]  limit_q
);
   // R3: only masked bits may change on an enable write
   a_r3_masked_update: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !cfg_addr) |=>
         (((en_q ^ $past(en_q)) & ~$past(cfg_wdata[2*PINS-1:PINS])) == '0));

   // R3: enable bits hold without an enable write
   a_r3_hold_no_write: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && !cfg_addr) |=> $stable(en_q));

   // R6: zero count forces pass-through on every pin
   a_r6_zero_bypass: assert property (@(posedge clk) disable iff (rst)
      (limit_q == '0) |-> (pin_flt == pin_raw));

   for (genvar i = 0; i < PINS; i++) begin : g_pin_chk
      // R2: disabled pin follows its raw level
      a_r2_disabled_follows: assert property (@(posedge clk) disable iff (rst)
         !en_q[i] |-> (pin_flt[i] == pin_raw[i]));

      // R9: a debounced output moves only on a tick edge
      a_r9_change_on_tick: assert property (@(posedge clk) disable iff (rst)
         (en_q[i] && (limit_q != '0) && $past(en_q[i]) && ($past(limit_q) != '0)
          && (pin_flt[i] != $past(pin_flt[i]))) |-> $past(ms_tick));
   end
endmodule

bind port_debounce pdb_checker #(
   .PINS  (PINS),
   .CNT_W (CNT_W)
) u_pdb_checker (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .ms_tick   (ms_tick),
   .pin_raw   (pin_raw),
   .pin_flt   (pin_flt),
   .en_q      (en_q),
   .limit_q   (limit_q)
);

// File: tb/port_debounce_test.sv
module port_debounce_test;
   localparam int PINS  = 8;
   localparam int CNT_W = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cfg_we = 1'b0;
   logic              cfg_addr = 1'b0;
   logic [2*PINS-1:0] cfg_wdata = '0;
   logic              ms_tick = 1'b0;
   logic [PINS-1:0]   pin_raw = 8'hA5;
   logic [PINS-1:0]   pin_flt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   port_debounce #(.PINS(PINS), .CNT_W(CNT_W)) uut (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .ms_tick   (ms_tick),
      .pin_raw   (pin_raw),
      .pin_flt   (pin_flt)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic chk_pin(input string tag, input int idx, input logic exp);
      #1;
      checks++;
      if (pin_flt[idx] !== exp) begin
         errors++;
         $display("FAIL %s pin%0d actual=%b expected=%b", tag, idx, pin_flt[idx], exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [PINS-1:0] exp);
      #1;
      checks++;
      if (pin_flt !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, pin_flt, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic set_pin(input int idx, input logic v);
      @(negedge clk) pin_raw[idx] = v;
   endtask

   task automatic wr(input logic a, input logic [2*PINS-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      idle(3);
      rst = 1'b0;
      chk_all("R1 reset loads raw", 8'hA5);
      @(negedge clk) pin_raw = 8'h5A;
      chk_all("R1 enables cleared after reset", 8'h5A);
   endtask

   task automatic t_mask();
      wr(1'b1, 16'd3);
      wr(1'b0, 16'h0101);
      wr(1'b0, 16'h00FE);
      set_pin(0, 1'b1);
      chk_pin("R3 unmasked write kept pin0 enabled", 0, 1'b0);
      set_pin(1, 1'b0);
      chk_pin("R2 R3 pin1 still bypassed", 1, 1'b0);
      set_pin(0, 1'b0);
      idle(2);
      wr(1'b0, 16'h01FE);
      set_pin(0, 1'b1);
      chk_pin("R3 masked write disabled pin0", 0, 1'b1);
      wr(1'b0, 16'hFF00);
   endtask

   task automatic t_basic();
      set_pin(2, 1'b0);
      idle(2);
      wr(1'b1, 16'd5);
      wr(1'b0, 16'h0404);
      set_pin(2, 1'b1);
      idle(2);
      tick(4);
      chk_pin("R4 held before count", 2, 1'b0);
      tick(1);
      chk_pin("R4 updated on Nth tick", 2, 1'b1);
      set_pin(2, 1'b0);
      idle(5);
      chk_pin("R9 no change without tick", 2, 1'b1);
      tick(5);
      chk_pin("R4 falling level after count", 2, 1'b0);
   endtask

   task automatic t_glitch();
      set_pin(2, 1'b1);
      idle(2);
      tick(3);
      set_pin(2, 1'b0);
      set_pin(2, 1'b1);
      idle(2);
      tick(4);
      chk_pin("R5 glitch restarted count", 2, 1'b0);
      tick(1);
      chk_pin("R5 update after full count", 2, 1'b1);
   endtask

   task automatic t_return();
      set_pin(2, 1'b0);
      idle(2);
      tick(4);
      set_pin(2, 1'b1);
      idle(2);
      tick(10);
      chk_pin("R10 return before expiry keeps output", 2, 1'b1);
   endtask

   task automatic t_lower();
      wr(1'b1, 16'd10);
      set_pin(2, 1'b0);
      idle(2);
      tick(6);
      chk_pin("R8 held at count 10", 2, 1'b1);
      wr(1'b1, 16'd2);
      tick(1);
      chk_pin("R8 lowered count updates on next tick", 2, 1'b0);
      wr(1'b0, 16'hFF00);
   endtask

   task automatic t_shared();
      @(negedge clk);
      pin_raw[3] = 1'b0; pin_raw[4] = 1'b0; pin_raw[5] = 1'b0;
      idle(2);
      wr(1'b0, 16'h1818);
      wr(1'b1, 16'd3);
      set_pin(3, 1'b1);
      idle(2);
      tick(1);
      set_pin(4, 1'b1);
      idle(2);
      tick(2);
      chk_pin("R7 first pin after shared count", 3, 1'b1);
      chk_pin("R7 second pin still counting", 4, 1'b0);
      tick(1);
      chk_pin("R7 second pin after own count", 4, 1'b1);
      set_pin(5, 1'b1);
      chk_pin("R2 disabled pin immediate", 5, 1'b1);
   endtask

   task automatic t_zero();
      wr(1'b1, 16'd0);
      set_pin(3, 1'b0);
      chk_pin("R6 zero count passes through", 3, 1'b0);
   endtask

   task automatic t_max();
      wr(1'b1, 16'd255);
      set_pin(4, 1'b0);
      idle(2);
      tick(254);
      chk_pin("R4 max count held at 254", 4, 1'b1);
      tick(1);
      chk_pin("R4 max count update at 255", 4, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_mask();
      t_basic();
      t_glitch();
      t_return();
      t_lower();
      t_shared();
      t_zero();
      t_max();
      summary();
      $finish;
   end
endmodule